// File: doc/BRIEF.md
# Memory Burst Termination Controller

This block follows one burst transfer between a bus master and a memory device and decides on every clock whether another beat may follow. A start strobe loads a byte start address, a beat-limit setting and a port width. From then on the block presents the current beat address and advances it by the port width on each acknowledged beat. The burst ends on the first of three events: the master asks to stop, the beat count reaches the programmed limit, or the next beat would cross a 64-byte page.

When a burst ends, the block raises a one-clock completion pulse and reports which event ended it. If several events occur in the same cycle, a fixed priority decides which one is reported. The start address does not have to be aligned.

For every active beat the block also fills two command slots in the style of SDRAM commands. The first slot opens the row when the row is not already open. The second slot carries the read or write command, because write data is valid only in that slot.

Top module: `burst_term_ctrl`

## Requirements
- R1: After reset the block is idle: busy=0, burstDone=0, lastBeat=0, doneCause=2'b00, and both command slots are NOP (2'b00).
- R2: A start strobe while idle loads a start address at any byte alignment. On the next clock, busy=1 and beatAddr equals that address.
- R3: Each acknowledged beat that does not end the burst advances beatAddr by the port width in bytes. portWidth 2'b00 gives 1 byte, 2'b01 gives 2 bytes, and 2'b10 or 2'b11 gives 4 bytes. Without an acknowledge, beatAddr holds its value.
- R4: The beat limit is 2 for sizeSel 2'b00, 4 for 2'b01, 8 for 2'b10 and 16 for 2'b11. A burst ended by the limit reports doneCause=2'b11.
- R5: An acknowledged beat is the last beat when its address offset within the 64-byte page, plus the port width, reaches 64 or more. A burst ended this way reports doneCause=2'b10.
- R6: masterStop high in any busy cycle ends the burst at that clock, with or without beatAck, and reports doneCause=2'b01.
- R7: When causes coincide, the reported cause follows this priority: master stop first, then page boundary, then beat limit.
- R8: burstDone is high for exactly the one clock after the ending edge. busy is low in that same clock. doneCause keeps its value until the next burst ends.
- R9: lastBeat is high during a busy cycle exactly when an acknowledge in that cycle would end the burst by page boundary or by beat limit.
- R10: A start strobe while busy is ignored. The address sequence and the beat limit of the running burst do not change.
- R11: Command slot encoding is NOP=2'b00, ACTIVATE=2'b01, READ=2'b10, WRITE=2'b11. While busy, cmdT1 is NOP when rowOpen=1 and ACTIVATE when rowOpen=0. cmdT2 is WRITE for a write burst and READ for a read burst, with the direction latched from writeSel at start. While idle, both slots are NOP.
- R12: With a 4-byte port and a 4-beat limit, a burst starting at 0x0C runs beats 0x0C, 0x10, 0x14 and 0x18 and ends by the beat limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | Burst start strobe |
| startAddr | input | ADDR_W | Start byte address |
| sizeSel | input | 2 | Beat-limit setting |
| portWidth | input | 2 | Port width setting |
| writeSel | input | 1 | 1 = write burst, latched at start |
| beatAck | input | 1 | Current beat acknowledged |
| masterStop | input | 1 | Master ends the burst |
| rowOpen | input | 1 | Row already open, no activate needed |
| busy | output | 1 | Burst in progress |
| beatAddr | output | ADDR_W | Current beat byte address |
| lastBeat | output | 1 | Current beat is the final one |
| burstDone | output | 1 | One-clock completion pulse |
| doneCause | output | 2 | Cause of the most recent termination |
| cmdT1 | output | 2 | First command slot |
| cmdT2 | output | 2 | Second command slot |

## Verification
The bench sweeps every page offset under every width and size setting. It predicts the number of beats arithmetically, so a page check that is off by one byte shows up as a burst one beat too long or too short at the offsets near 64. Bursts in which the page and limit events coincide catch a wrong priority, which would report 2'b11 where 2'b10 is due. Master stops placed on every beat, including the beat where another cause also fires and cycles with no acknowledge, catch a stop that waits for beatAck or loses to another cause. Start strobes in the middle of a burst catch a design that reloads the address or limit.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_STOP  = 2'b01,
    CAUSE_PAGE  = 2'b10,
    CAUSE_COUNT = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic clear;
  } dpCtl_t;

endpackage

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 64,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        sizeSel,
  input  logic [1:0]        portWidth,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              limitHit,
  output logic              pageHit
);

  localparam int PB = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  limitQ;
  logic [2:0]        stepQ;

  function automatic logic [2:0] stepOf(input logic [1:0] pw);
    case (pw)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      cntQ   <= '0;
      limitQ <= CNT_W'(2);
      stepQ  <= 3'd1;
    end else if (ctl.load) begin
      addrQ  <= startAddr;
      cntQ   <= '0;
      limitQ <= CNT_W'(2) << sizeSel;
      stepQ  <= stepOf(portWidth);
    end else if (ctl.advance) begin
      addrQ <= addrQ + ADDR_W'(stepQ);
      cntQ  <= cntQ + CNT_W'(1);
    end else if (ctl.clear) begin
      cntQ <= '0;
    end
  end

  assign beatAddr = addrQ;
  assign limitHit = (cntQ + CNT_W'(1)) == limitQ;
  assign pageHit  = ({1'b0, addrQ[PB-1:0]} + (PB+1)'(stepQ)) >= (PB+1)'(PAGE_BYTES);

  // R4
  count_below_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < limitQ);

  // R5
  no_page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> addrQ[PB-1:0] > $past(addrQ[PB-1:0]));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load && !ctl.advance |=> $stable(addrQ));

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startStb,
  input  logic   beatAck,
  input  logic   masterStop,
  input  logic   writeSel,
  input  logic   rowOpen,
  input  logic   limitHit,
  input  logic   pageHit,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   lastBeat,
  output logic   burstDone,
  output cause_e doneCause,
  output cmd_e   cmdT1,
  output cmd_e   cmdT2
);

  logic   activeQ;
  logic   writeQ;
  logic   doneQ;
  cause_e causeQ;
  logic   endNow;
  cause_e causeNext;

  assign endNow = activeQ && (masterStop || (beatAck && (limitHit || pageHit)));

  always_comb begin
    if (masterStop)   causeNext = CAUSE_STOP;
    else if (pageHit) causeNext = CAUSE_PAGE;
    else              causeNext = CAUSE_COUNT;
  end

  always_comb begin
    ctl.load    = !activeQ && startStb;
    ctl.advance = activeQ && beatAck && !endNow;
    ctl.clear   = endNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      writeQ  <= 1'b0;
      doneQ   <= 1'b0;
      causeQ  <= CAUSE_NONE;
    end else begin
      doneQ <= endNow;
      if (endNow) begin
        activeQ <= 1'b0;
        causeQ  <= causeNext;
      end else if (ctl.load) begin
        activeQ <= 1'b1;
        writeQ  <= writeSel;
      end
    end
  end

  always_comb begin
    cmdT1 = CMD_NOP;
    cmdT2 = CMD_NOP;
    if (activeQ) begin
      cmdT1 = rowOpen ? CMD_NOP : CMD_ACT;
      cmdT2 = writeQ ? CMD_WR : CMD_RD;
    end
  end

  assign busy      = activeQ;
  assign lastBeat  = activeQ && (limitHit || pageHit);
  assign burstDone = doneQ;
  assign doneCause = causeQ;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> !busy && doneCause != CAUSE_NONE);

  // R10
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startStb) && !$past(burstDone && busy));

  // R6
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && masterStop |=> burstDone && doneCause == CAUSE_STOP);

  // R11
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> cmdT1 == CMD_NOP && cmdT2 == CMD_NOP);

  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !burstDone && $past(!burstDone) |-> $stable(doneCause));

endmodule

// File: rtl/burst_term_ctrl.sv
module burst_term_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 64,
  parameter int MAX_BEATS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        sizeSel,
  input  logic [1:0]        portWidth,
  input  logic              writeSel,
  input  logic              beatAck,
  input  logic              masterStop,
  input  logic              rowOpen,
  output logic              busy,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              lastBeat,
  output logic              burstDone,
  output logic [1:0]        doneCause,
  output logic [1:0]        cmdT1,
  output logic [1:0]        cmdT2
);

  localparam int CNT_W = $clog2(MAX_BEATS) + 1;

  dpCtl_t ctl;
  logic   limitHit;
  logic   pageHit;
  cause_e causeW;
  cmd_e   cmd1W;
  cmd_e   cmd2W;

  burst_dp #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startAddr(startAddr),
    .sizeSel  (sizeSel),
    .portWidth(portWidth),
    .beatAddr (beatAddr),
    .limitHit (limitHit),
    .pageHit  (pageHit)
  );

  burst_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .beatAck   (beatAck),
    .masterStop(masterStop),
    .writeSel  (writeSel),
    .rowOpen   (rowOpen),
    .limitHit  (limitHit),
    .pageHit   (pageHit),
    .ctl       (ctl),
    .busy      (busy),
    .lastBeat  (lastBeat),
    .burstDone (burstDone),
    .doneCause (causeW),
    .cmdT1     (cmd1W),
    .cmdT2     (cmd2W)
  );

  assign doneCause = causeW;
  assign cmdT1     = cmd1W;
  assign cmdT2     = cmd2W;

endmodule

// File: tb/burst_term_ctrl_tb.sv
module burst_term_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic [15:0] startAddr = '0;
  logic [1:0]  sizeSel = '0;
  logic [1:0]  portWidth = '0;
  logic        writeSel = 1'b0;
  logic        beatAck = 1'b0;
  logic        masterStop = 1'b0;
  logic        rowOpen = 1'b0;
  logic        busy, lastBeat, burstDone;
  logic [15:0] beatAddr;
  logic [1:0]  doneCause, cmdT1, cmdT2;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst_term_ctrl u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
    .sizeSel(sizeSel), .portWidth(portWidth), .writeSel(writeSel),
    .beatAck(beatAck), .masterStop(masterStop), .rowOpen(rowOpen),
    .busy(busy), .beatAddr(beatAddr), .lastBeat(lastBeat),
    .burstDone(burstDone), .doneCause(doneCause), .cmdT1(cmdT1), .cmdT2(cmdT2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one burst; stopAt < 0 means no master stop.
  task automatic runBurst(input int s, input int w, input int sz, input int stopAt,
                          input bit stopNoAck, input bit gaps, input bit poke,
                          input bit wr);
    int wb, lim, off, pageBeats, n, endK, expCause;
    wb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    lim = 2 << sz;
    off = s % 64;
    pageBeats = (64 - off + wb - 1) / wb;
    n = (pageBeats < lim) ? pageBeats : lim;
    if (stopAt >= 0 && stopAt < n) begin
      endK = stopAt; expCause = 1;
    end else begin
      endK = n - 1; expCause = (pageBeats <= lim) ? 2 : 3;
    end
    @(negedge clk);
    startStb = 1'b1; startAddr = 16'(s); sizeSel = 2'(sz);
    portWidth = 2'(w); writeSel = wr;
    @(negedge clk);
    startStb = 1'b0;
    for (int k = 0; k <= endK; k++) begin
      if (gaps) begin
        beatAck = 1'b0; masterStop = 1'b0; rowOpen = 1'b1;
        #1;
        chk(busy && beatAddr == 16'(s + k * wb), "R3 hold without ack", beatAddr, s + k * wb);
        @(negedge clk);
      end
      beatAck = !(k == stopAt && stopNoAck);
      masterStop = (k == stopAt);
      rowOpen = k[0];
      if (poke && k == 1) begin
        startStb = 1'b1; startAddr = 16'h3F00; sizeSel = 2'b00; portWidth = 2'b00;
      end else begin
        startStb = 1'b0;
      end
      #1;
      chk(busy == 1'b1, "R2 busy", busy, 1);
      chk(beatAddr == 16'(s + k * wb), (poke ? "R10 address" : "R3 address"),
          beatAddr, s + k * wb);
      chk(lastBeat == (k == n - 1), "R9 lastBeat", lastBeat, k == n - 1);
      chk(cmdT1 == (k[0] ? 2'b00 : 2'b01), "R11 slot1", cmdT1, k[0] ? 0 : 1);
      chk(cmdT2 == (wr ? 2'b11 : 2'b10), "R11 slot2", cmdT2, wr ? 3 : 2);
      @(negedge clk);
    end
    startStb = 1'b0; beatAck = 1'b0; masterStop = 1'b0;
    #1;
    chk(burstDone == 1'b1 && busy == 1'b0, "R8 done pulse", {busy, burstDone}, 1);
    chk(doneCause == 2'(expCause),
        (expCause == 1) ? "R6 stop cause" : (expCause == 2) ? "R5 page cause" : "R4 limit cause",
        doneCause, expCause);
    @(negedge clk);
    #1;
    chk(burstDone == 1'b0, "R8 single pulse", burstDone, 0);
    chk(doneCause == 2'(expCause), "R8 cause held", doneCause, expCause);
    chk(cmdT1 == 2'b00 && cmdT2 == 2'b00, "R11 idle NOP", {cmdT1, cmdT2}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!busy && !burstDone && !lastBeat, "R1 reset flags", {busy, burstDone, lastBeat}, 0);
    chk(doneCause == 2'b00, "R1 reset cause", doneCause, 0);
    chk(cmdT1 == 2'b00 && cmdT2 == 2'b00, "R1 reset slots", {cmdT1, cmdT2}, 0);
    rstN = 1'b1;

    // R12: worked example, 4-byte port, 4 beats from 0x0C
    runBurst(16'h000C, 2, 1, -1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R2 R3 R4 R5 R7: sweep every offset, width and size
    for (int w = 0; w < 4; w++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 64; off++)
          runBurst(16'h1240 + off, w, sz, -1, 1'b0, (off % 5) == 0,
                   (off % 7) == 3, off[0]);

    // R6 R7: master stop on every beat, with and without ack
    for (int w = 0; w < 3; w++)
      for (int off = 40; off < 64; off += 3)
        for (int j = 0; j < 16; j++)
          runBurst(16'h0800 + off, w, 3, j, j[0], 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule